// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block divides a selectable tick stream down to a square-wave bit clock. Software loads a 16-bit time constant one byte at a time, picks which of two clock-enable sources drives the divider, and turns counting on or off. The counter steps down once per accepted tick. When it hits zero it flips the bit clock, emits a one-cycle zero-count pulse, and spends one more tick reloading the time constant. Each half period is therefore the time constant plus two ticks, and the output frequency is the tick rate divided by twice that sum.

The ticks are single-cycle enables in the system clock domain. One comes from the system-clock divider path and one from an external clock pin or crystal path that has already been synchronised. The zero-count pulse is meant for a status latch that may raise an interrupt. That latch and the interrupt logic sit outside this block.

Top module: `baud_divider`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `baudOut` and `zeroPulse` are 0.
- R2: A write strobe on `tcLoWr` stores `wrByte` as bits 7:0 of the time constant. A strobe on `tcHiWr` stores it as bits 15:8. The divider uses the full 16-bit value {high, low}.
- R3: With a time constant TC in effect, `baudOut` toggles once every TC+2 accepted ticks. A full output period is 2·(TC+2) ticks.
- R4: `zeroPulse` is high for exactly one cycle at each terminal count. That cycle is the one in which `baudOut` shows its new level, and `baudOut` never changes in any other cycle.
- R5: While `brgEnable` is 0, ticks are not counted, `baudOut` holds its level and `zeroPulse` stays 0. Once re-enabled, counting resumes from the held count.
- R6: With `srcSel`=1 only `sysTick` is accepted as a tick. With `srcSel`=0 only `extTick` is accepted. Ticks on the unselected source have no effect.
- R7: A time-constant write does not alter the half period already in progress. The new value is loaded at the next reload tick, which is the first accepted tick after a terminal count.
- R8: After reset the first accepted tick is a reload tick. The first toggle of `baudOut` therefore comes on accepted tick TC+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tcLoWr | input | 1 | Write strobe for the low time-constant byte |
| tcHiWr | input | 1 | Write strobe for the high time-constant byte |
| wrByte | input | 8 | Byte written by either strobe |
| brgEnable | input | 1 | Counting enable |
| srcSel | input | 1 | Tick source: 1 = sysTick, 0 = extTick |
| sysTick | input | 1 | Clock enable from the system clock path |
| extTick | input | 1 | Clock enable from the external pin or crystal path |
| baudOut | output | 1 | Square-wave bit clock |
| zeroPulse | output | 1 | One-cycle terminal-count status pulse |

## Verification
The bench builds the block with its default 8-bit byte lanes, which give the full 16-bit time constant.

It programs a range of time constants:
- zero, which gives the shortest two-tick half period with back-to-back pulses two cycles apart;
- small values, which let several periods and a mid-count rewrite fit in a few dozen cycles;
- a value with a nonzero high byte (258), which proves the lane order within a few hundred ticks.

Sparse and mixed tick patterns on both sources, and a long disabled window, show that only accepted ticks move the count.

// File: rtl/baud_divider_pkg.sv
package baud_divider_pkg;
  // Per-cycle command from control to datapath
  typedef struct packed {
    logic load;      // reload tick: copy time constant into counter
    logic dec;       // ordinary tick: step counter down
    logic terminal;  // zero tick: flip output, raise status pulse
  } brgStrobe_t;
endpackage

// File: rtl/baud_divider_ctrl.sv
module baud_divider_ctrl
  import baud_divider_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       brgEnable,
  input  logic       srcSel,
  input  logic       sysTick,
  input  logic       extTick,
  input  logic       cntZero,
  output brgStrobe_t strobe
);
  logic tickSel;
  logic tick;
  logic inReload;

  // Source mux: only the chosen enable counts
  assign tickSel = srcSel ? sysTick : extTick;
  assign tick    = brgEnable & tickSel;

  always_comb begin
    strobe.load     = tick & inReload;
    strobe.terminal = tick & ~inReload & cntZero;
    strobe.dec      = tick & ~inReload & ~cntZero;
  end

  // Phase flag: reset lands in the reload phase so the first tick loads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                inReload <= 1'b1;
    else if (strobe.load)     inReload <= 1'b0;
    else if (strobe.terminal) inReload <= 1'b1;
  end
endmodule

// File: rtl/baud_divider_dp.sv
module baud_divider_dp
  import baud_divider_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NUM_BYTES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_BYTES-1:0] laneWr,
  input  logic [BYTE_W-1:0] wrByte,
  input  brgStrobe_t        strobe,
  output logic              cntZero,
  output logic              baudOut,
  output logic              zeroPulse
);
  localparam int TC_W = BYTE_W * NUM_BYTES;

  logic [TC_W-1:0] tcReg;
  logic [TC_W-1:0] cnt;

  // One holding register per byte lane
  for (genvar lane = 0; lane < NUM_BYTES; lane++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             tcReg[lane*BYTE_W +: BYTE_W] <= '0;
      else if (laneWr[lane]) tcReg[lane*BYTE_W +: BYTE_W] <= wrByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (strobe.load) cnt <= tcReg;
    else if (strobe.dec)  cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baudOut   <= 1'b0;
      zeroPulse <= 1'b0;
    end else begin
      zeroPulse <= strobe.terminal;
      if (strobe.terminal) baudOut <= ~baudOut;
    end
  end
endmodule

// File: rtl/baud_divider.sv
module baud_divider
  import baud_divider_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tcLoWr,
  input  logic              tcHiWr,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic              brgEnable,
  input  logic              srcSel,
  input  logic              sysTick,
  input  logic              extTick,
  output logic              baudOut,
  output logic              zeroPulse
);
  brgStrobe_t strobe;
  logic       cntZero;

  baud_divider_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .brgEnable(brgEnable), .srcSel(srcSel),
    .sysTick(sysTick), .extTick(extTick), .cntZero(cntZero), .strobe(strobe)
  );

  baud_divider_dp #(.BYTE_W(BYTE_W), .NUM_BYTES(2)) dp_i (
    .clk(clk), .rstN(rstN), .laneWr({tcHiWr, tcLoWr}), .wrByte(wrByte),
    .strobe(strobe), .cntZero(cntZero), .baudOut(baudOut), .zeroPulse(zeroPulse)
  );
endmodule

// File: rtl/baud_divider_chk.sv
module baud_divider_chk (
  input logic clk,
  input logic rstN,
  input logic brgEnable,
  input logic srcSel,
  input logic sysTick,
  input logic extTick,
  input logic baudOut,
  input logic zeroPulse
);
  // R1: clean outputs on the first cycle out of reset
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!baudOut && !zeroPulse));

  // R4: pulse accompanies every toggle
  a_r4_pulse_means_toggle: assert property (@(posedge clk) disable iff (!rstN)
    zeroPulse |-> (baudOut != $past(baudOut)));

  // R4: output never moves without a pulse
  a_r4_toggle_means_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (baudOut != $past(baudOut)) |-> zeroPulse);

  // R4: pulse lasts one cycle
  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    zeroPulse |=> !zeroPulse);

  // R5: disabled cycle cannot cause a terminal count
  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !brgEnable |=> (!zeroPulse && $stable(baudOut)));

  // R6: cycle without a tick on the chosen source changes nothing
  a_r6_unselected_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel ? !sysTick : !extTick) |=> (!zeroPulse && $stable(baudOut)));
endmodule

bind baud_divider baud_divider_chk chk_i (
  .clk(clk), .rstN(rstN), .brgEnable(brgEnable), .srcSel(srcSel),
  .sysTick(sysTick), .extTick(extTick), .baudOut(baudOut), .zeroPulse(zeroPulse)
);

// File: tb/baud_divider_tb_top.sv
module baud_divider_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tcLoWr = 1'b0, tcHiWr = 1'b0;
  logic [7:0] wrByte = '0;
  logic brgEnable = 1'b0, srcSel = 1'b1, sysTick = 1'b0, extTick = 1'b0;
  logic baudOut, zeroPulse;

  always #2.5 clk = ~clk;

  baud_divider dut_i (
    .clk(clk), .rstN(rstN), .tcLoWr(tcLoWr), .tcHiWr(tcHiWr), .wrByte(wrByte),
    .brgEnable(brgEnable), .srcSel(srcSel), .sysTick(sysTick), .extTick(extTick),
    .baudOut(baudOut), .zeroPulse(zeroPulse)
  );

  int nChecks = 0;
  int nBad = 0;
  string curReq = "R3";

  // Reference model state, built from the requirements
  int effTicks = 0;
  int remain = 0;
  logic startHalf = 1'b1;
  logic [15:0] shadowTc = '0;
  logic modelLvl = 1'b0;
  int expTick[$];
  logic expLvl[$];

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes expected toggles
  task automatic step(input logic s, input logic e, input logic en, input logic sel,
                      input logic wl, input logic wh, input logic [7:0] d);
    logic eff;
    @(negedge clk);
    sysTick = s; extTick = e; brgEnable = en; srcSel = sel;
    tcLoWr = wl; tcHiWr = wh; wrByte = d;
    eff = en && (sel ? s : e);
    if (eff) begin
      effTicks++;
      if (startHalf) begin
        remain = int'(shadowTc) + 2;  // R7: value before this cycle's write
        startHalf = 1'b0;
      end
      remain--;
      if (remain == 0) begin
        modelLvl = ~modelLvl;
        expTick.push_back(effTicks);
        expLvl.push_back(modelLvl);
        startHalf = 1'b1;
      end
    end
    if (wl) shadowTc[7:0] = d;
    if (wh) shadowTc[15:8] = d;
  endtask

  task automatic writeTc(input logic [15:0] v, input logic en, input logic sel);
    step(1'b0, 1'b0, en, sel, 1'b1, 1'b0, v[7:0]);
    step(1'b0, 1'b0, en, sel, 1'b0, 1'b1, v[15:8]);
  endtask

  // Monitor: compares each pulse against the scoreboard
  logic prevOut = 1'b0;
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      if (zeroPulse) begin
        if (expTick.size() == 0) begin
          check(1'b0, {curReq, " R4 unexpected pulse"}, effTicks, -1);
        end else begin
          int t;
          logic l;
          t = expTick.pop_front();
          l = expLvl.pop_front();
          check(t == effTicks, {curReq, " R3 toggle tick"}, effTicks, t);
          check(baudOut == l, {curReq, " R4 level"}, int'(baudOut), int'(l));
        end
      end else if (baudOut != prevOut) begin
        check(1'b0, "R4 toggle without pulse", int'(baudOut), int'(prevOut));
      end
      prevOut = baudOut;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", nChecks + 1, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(baudOut == 1'b0 && zeroPulse == 1'b0, "R1 in reset", int'({baudOut, zeroPulse}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(baudOut == 1'b0 && zeroPulse == 1'b0, "R1 after release", int'({baudOut, zeroPulse}), 0);

    // R8 and R3: TC=3 on the system source, first toggle on tick 5
    curReq = "R8";
    writeTc(16'd3, 1'b0, 1'b1);
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    curReq = "R3";
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);

    // R7: rewrite to zero mid-count; current half finishes with TC=3
    curReq = "R7";
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);

    // R2 and R6: TC=0x0102 on the external source; sys ticks ignored
    curReq = "R2 R6";
    writeTc(16'h0102, 1'b1, 1'b0);
    for (int i = 0; i < 700; i++) step(i[0], 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);

    // R5: disabled with ticks on both sources
    curReq = "R5";
    for (int i = 0; i < 60; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check(baudOut == modelLvl, "R5 level held", int'(baudOut), int'(modelLvl));
    check(expTick.size() == 0, "R5 no pending", expTick.size(), 0);
    for (int i = 0; i < 400; i++) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);

    // R6: sparse external ticks on the system selection are ignored
    curReq = "R6";
    writeTc(16'd5, 1'b1, 1'b1);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 150; i++) step(1'b0, (i % 3) == 0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    curReq = "R3";
    for (int i = 0; i < 150; i++) step((i % 3) == 0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);

    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    check(expTick.size() == 0, "R3 all toggles seen", expTick.size(), 0);
    check(baudOut == modelLvl, "R3 final level", int'(baudOut), int'(modelLvl));
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule